// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This block drives a fixed number of clock pulses onto a configuration port. It is started through a small 32-bit register interface with a 4-byte stride. Software, or a nearby sequencer, first clears the done flag. It then writes a pulse count to the count register, and that write starts the burst. The block raises `busy` and emits the pulses on `burst_clk`. When the last pulse has finished, it sets a sticky done flag in the status register.

Each pulse is derived from the system clock. The high phase lasts `HALF_DIV` system cycles and the low phase lasts another `HALF_DIV` cycles. `HALF_DIV` is a parameter. Typical uses are a burst of 256 pulses that clears out stale errors, and a burst of 2047 pulses that runs ahead of data streaming.

Top module: `cfg_clk_burst`

## Requirements
- R1: A write to byte offset 0x08 while idle starts a burst of exactly N pulses, where N is `reg_wdata[CNT_W-1:0]`. `busy` rises at the clock edge that accepts the write and stays high for 2·N·HALF_DIV cycles.
- R2: Each pulse is high for HALF_DIV cycles and then low for HALF_DIV cycles. The first pulse rises at the edge that accepts the write. `burst_clk` is low whenever `busy` is low.
- R3: Bit 0 of the status register (byte offset 0x0C) is the done flag. It is set at the same edge where the final low phase ends, and `busy` falls at that same edge.
- R4: The done flag holds until a status write with bit 0 equal to 1 clears it. A status write with bit 0 equal to 0 leaves it unchanged. If a finish and a clear fall in the same cycle, the flag ends up set.
- R5: A count of zero sets the done flag at the edge that accepts the write. No pulse is emitted and `busy` stays low.
- R6: A count write while `busy` is high is ignored. The running burst keeps its original pulse count.
- R7: Reads are combinational from `reg_addr`:
  - offset 0x0C returns the live done flag in bit 0 and zeros above it;
  - offset 0x08 returns the number of pulses still to be emitted, which is 0 when idle;
  - every other offset returns 0.
- R8: After reset, `burst_clk`, `busy` and the done flag are all 0.
- R9: Bursts of 256 and of 2047 pulses complete with exact counts. The count field is at least 11 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, sampled at the rising edge |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| burst_clk | output | 1 | Configuration clock pulse output |
| busy | output | 1 | High while a burst is running |

## Verification
The assertions check on every cycle these properties:
- `burst_clk` stays low while idle, and each phase holds between divider ends;
- `busy` drops and the flag sets on the final tick, and a zero count never raises `busy`;
- the flag is sticky and clears on a write of 1;
- the remaining count never grows during a burst, which covers ignored reloads.

Only the bench scenarios can show the following:
- that exactly N pulses appear, each run exactly HALF_DIV long;
- that the busy window has the right total length;
- that a set wins over a clear in the same cycle;
- that register reads return the values each requirement states.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;

  localparam int unsigned OFS_COUNT  = 32'h08;
  localparam int unsigned OFS_STATUS = 32'h0C;

  // number of system cycles a burst of n pulses keeps busy high
  function automatic int unsigned burst_cycles(input int unsigned n, input int unsigned half);
    return 2 * n * half;
  endfunction

  // width of a divider counter that counts 0..half-1
  function automatic int unsigned div_width(input int unsigned half);
    return (half > 1) ? $clog2(half) : 1;
  endfunction

endpackage

// File: rtl/cfgclk_regif.sv
module cfgclk_regif
  import cfgclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              eng_finish,
  input  logic [CNT_W-1:0]  eng_remaining,
  output logic              load_req,
  output logic [CNT_W-1:0]  load_val,
  output logic              done_flag,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int WI_W = ADDR_W - 2;
  localparam logic [WI_W-1:0] W_COUNT  = WI_W'(OFS_COUNT  >> 2);
  localparam logic [WI_W-1:0] W_STATUS = WI_W'(OFS_STATUS >> 2);

  logic [WI_W-1:0] word_idx;
  logic            sel_count, sel_status, clr_req;

  assign word_idx   = reg_addr[ADDR_W-1:2];
  assign sel_count  = (word_idx == W_COUNT);
  assign sel_status = (word_idx == W_STATUS);
  assign load_req   = reg_wr && sel_count;
  assign load_val   = reg_wdata[CNT_W-1:0];
  assign clr_req    = reg_wr && sel_status && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_flag <= 1'b0;
    else if (eng_finish) done_flag <= 1'b1;
    else if (clr_req)    done_flag <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_status)     reg_rdata[0] = done_flag;
    else if (sel_count) reg_rdata[CNT_W-1:0] = eng_remaining;
  end

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !clr_req |=> done_flag);
  p_finish_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_finish |=> done_flag);
  p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !eng_finish |=> !done_flag);

endmodule

// File: rtl/cfgclk_pulse_engine.sv
module cfgclk_pulse_engine
  import cfgclk_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             burst_clk,
  output logic             finish,
  output logic [CNT_W-1:0] remaining
);

  localparam int DIV_W = div_width(HALF_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy_q, phase_hi;
  logic [CNT_W-1:0] rem_q;
  logic [DIV_W-1:0] div_q;
  logic             accept, half_end, last_tick, zero_start;

  assign accept     = load_req && !busy_q;
  assign zero_start = accept && (load_val == '0);
  assign half_end   = busy_q && (div_q == DIV_LAST);
  assign last_tick  = half_end && !phase_hi && (rem_q == CNT_W'(1));
  assign finish     = zero_start || last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      phase_hi <= 1'b0;
      rem_q    <= '0;
      div_q    <= '0;
    end else if (accept) begin
      if (load_val != '0) begin
        busy_q   <= 1'b1;
        phase_hi <= 1'b1;
        rem_q    <= load_val;
        div_q    <= '0;
      end
    end else if (busy_q) begin
      if (half_end) begin
        div_q <= '0;
        if (phase_hi) begin
          phase_hi <= 1'b0;
        end else begin
          rem_q    <= rem_q - CNT_W'(1);
          phase_hi <= (rem_q != CNT_W'(1));
          if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign busy      = busy_q;
  assign burst_clk = phase_hi;
  assign remaining = rem_q;

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !burst_clk);
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !half_end |=> $stable(burst_clk));
  p_last_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> !busy_q && !burst_clk && rem_q == '0);
  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && load_req |=> rem_q <= $past(rem_q));
  p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> !busy_q && !burst_clk);

endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst
  import cfgclk_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 12,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              burst_clk,
  output logic              busy
);

  logic             load_req, eng_finish, done_flag;
  logic [CNT_W-1:0] load_val, eng_remaining;

  cfgclk_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_finish(eng_finish), .eng_remaining(eng_remaining),
    .load_req(load_req), .load_val(load_val), .done_flag(done_flag),
    .reg_rdata(reg_rdata)
  );

  cfgclk_pulse_engine #(.CNT_W(CNT_W), .HALF_DIV(HALF_DIV)) u_engine (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_val(load_val),
    .busy(busy), .burst_clk(burst_clk), .finish(eng_finish),
    .remaining(eng_remaining)
  );

  p_finish_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

endmodule

// File: tb/cfg_clk_burst_test.sv
module cfg_clk_burst_test;

  localparam int HALF = 2;
  localparam int NV   = 6;
  // vector fields: [13:2] pulse count, [1] reload while busy, [0] clear at the finishing edge
  localparam logic [13:0] VEC [NV] = '{
    {12'd1,    1'b0, 1'b0},
    {12'd3,    1'b0, 1'b0},
    {12'd256,  1'b0, 1'b0},
    {12'd2047, 1'b0, 1'b0},
    {12'd5,    1'b1, 1'b0},
    {12'd2,    1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        burst_clk, busy;

  int n_chk = 0;
  int n_bad = 0;

  cfg_clk_burst #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .burst_clk(burst_clk), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic run_vec(input int n, input bit rew, input bit clr_end);
    int v, cycles, pulses, runlen, badrun;
    logic prev;
    wr(8'h0C, 32'h1);
    rd(8'h0C, v);
    chk(v == 0, "R4 clear before start", v, 0);
    wr(8'h08, 32'(n));
    chk(busy == 1'b1, "R1 busy after count write", int'(busy), 1);
    rd(8'h08, v);
    chk(v == n, "R7 remaining count read", v, n);
    cycles = 0; pulses = 0; runlen = 0; badrun = 0; prev = 1'b0;
    while (busy && cycles < 20000) begin
      cycles++;
      if (burst_clk != prev) begin
        if (runlen != 0 && runlen != HALF) badrun++;
        runlen = 1;
        if (burst_clk) pulses++;
      end else begin
        runlen++;
      end
      prev = burst_clk;
      reg_wr = 1'b0;
      if (rew && cycles == 4) begin
        reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'd9;
      end
      if (clr_end && cycles == 2 * n * HALF) begin
        reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h1;
      end
      @(negedge clk);
    end
    reg_wr = 1'b0;
    if (runlen != HALF) badrun++;
    chk(cycles == 2 * n * HALF, "R1 busy window length", cycles, 2 * n * HALF);
    if (rew) chk(pulses == n, "R6 reload ignored, pulse count", pulses, n);
    else if (n >= 256) chk(pulses == n, "R9 long burst pulse count", pulses, n);
    else chk(pulses == n, "R1 pulse count", pulses, n);
    chk(badrun == 0, "R2 phase widths", badrun, 0);
    chk(burst_clk == 1'b0, "R2 output low when idle", int'(burst_clk), 0);
    rd(8'h0C, v);
    if (clr_end) chk(v == 1, "R4 set beats clear", v, 1);
    else chk(v == 1, "R3 done after burst", v, 1);
    rd(8'h08, v);
    chk(v == 0, "R7 remaining zero when idle", v, 0);
  endtask

  initial begin
    int v, hi_seen;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(burst_clk == 1'b0, "R8 reset burst_clk", int'(burst_clk), 0);
    chk(busy == 1'b0, "R8 reset busy", int'(busy), 0);
    rd(8'h0C, v);
    chk(v == 0, "R8 reset done", v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(int'(VEC[i][13:2]), VEC[i][1], VEC[i][0]);
    end

    // R4: writing 0 to the done bit has no effect; writing 1 clears it
    wr(8'h0C, 32'h0);
    rd(8'h0C, v);
    chk(v == 1, "R4 write 0 keeps done", v, 1);
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h0C, v);
    chk(v == 1, "R4 bit0 clear only", v, 1);
    wr(8'h0C, 32'h1);
    rd(8'h0C, v);
    chk(v == 0, "R4 write 1 clears", v, 0);

    // R5: zero count
    wr(8'h08, 32'h0);
    rd(8'h0C, v);
    chk(v == 1, "R5 zero count sets done", v, 1);
    chk(busy == 1'b0, "R5 zero count not busy", int'(busy), 0);
    hi_seen = 0;
    for (int k = 0; k < 12; k++) begin
      if (burst_clk || busy) hi_seen++;
      @(negedge clk);
    end
    chk(hi_seen == 0, "R5 zero count no pulses", hi_seen, 0);

    // R7: unmapped offsets read zero
    rd(8'h00, v);
    chk(v == 0, "R7 unmapped read", v, 0);
    rd(8'h10, v);
    chk(v == 0, "R7 unmapped read high", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule